// File: doc/BRIEF.md
# Byte-Parallel BCH Systematic Encoder

This block produces systematic binary BCH codewords eight message bits at a time. A frame of message bytes enters on a byte-wide stream. Each accepted byte is copied to the output unchanged and is folded into a parity remainder in the same clock. The remainder update is the serial shift-register division unrolled over one byte. After the final message byte, the block stops taking input and sends the remainder out as parity bytes, most significant first. The last parity byte is marked.

One of four generator polynomials is chosen per frame. Their degrees are 128, 160, 168 and 192. A single 192-bit remainder register serves all of them. A shorter generator is multiplied by a power of x so that it fills the register from the top. Its remainder then sits in the uppermost bits and leaves first. The byte-step network is an XOR network. Its coefficients are derived when the design is elaborated, by running the serial division eight times for each polynomial.

Top module: `bch_par_enc`

## Requirements
- R1: After reset, out_valid and out_last are low and in_ready is high.
- R2: A message byte accepted on a clock edge (in_valid and in_ready high) appears on out_data one clock later with out_valid high and out_last low. Its value is unchanged.
- R3: In the clock after the final message byte appears on the output, parity output begins. Exactly deg/8 parity bytes follow on consecutive clocks. Together they form the remainder of m(x)·x^deg divided by g(x), sent highest coefficient first. Within each message byte, bit 7 is the first (highest-order) message bit.
- R4: out_last is high with the final parity byte of a frame and at no other time. in_ready is high again in that same cycle.
- R5: in_ready is low for exactly deg/8 cycles after the last message byte is accepted. in_valid during that time is ignored and produces no output byte.
- R6: in_sel is sampled on the byte that carries in_sof. Code 0, 1, 2 or 3 selects degree 128, 160, 168 or 192, using the tap constants in the package (bit i holds g_i, with the leading coefficient implied). Changes to in_sel later in the frame have no effect.
- R7: in_sof clears the remainder, so each frame's parity depends only on that frame's bytes. This holds even when frames follow each other with no idle cycle.
- R8: Idle cycles (in_valid low) between message bytes do not change the codeword.
- R9: A frame of a single message byte (in_sof and in_last together) is encoded correctly.
- R10: An all-zero message yields all-zero parity bytes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_sof | input | 1 | Marks the first message byte of a frame |
| in_valid | input | 1 | Message byte present |
| in_data | input | 8 | Message byte, bit 7 first |
| in_last | input | 1 | Marks the final message byte of a frame |
| in_sel | input | 2 | Generator polynomial choice |
| in_ready | output | 1 | Block can take a message byte |
| out_valid | output | 1 | Codeword byte present |
| out_data | output | 8 | Codeword byte |
| out_last | output | 1 | Final parity byte of the frame |

## Verification
A corrupted remainder, a wrong column constant or a wrong padding shift produces no visible fault while message bytes stream through. It shows up only in the first parity byte after in_last, which can be up to a frame later. For this reason every frame is compared byte by byte against a bit-serial division of the unpadded degree. The frames vary the polynomial, length, idle gaps and spacing. A fault in the parity counter or the latched select appears sooner: the number of parity bytes changes, or out_last and in_ready are placed wrongly. These are checked on each frame.

// File: rtl/bch_par_pkg.sv
// Shared constants for the byte-parallel BCH encoder.
// Assumes every degree is a multiple of the byte width and at most BCH_NMAX.
package bch_par_pkg;
    localparam int BCH_W     = 8;
    localparam int BCH_NMAX  = 192;
    localparam int BCH_NPOLY = 4;

    typedef logic [15:0] deg_t;

    // Degrees for select codes 3..0
    localparam logic [BCH_NPOLY-1:0][15:0] BCH_DEGS =
        {16'd192, 16'd168, 16'd160, 16'd128};

    // Low-order coefficients g_(deg-1)..g_0; the x^deg term is implied
    localparam logic [BCH_NPOLY-1:0][BCH_NMAX-1:0] BCH_TAPS = {
        192'hC4E1_9A3D_5B72_F08E_6D19_A4C3_7E52_B0F6_8A1D_3C95_E207_4B6F,
        192'h5E_1B9C_D274_0A3F_86E5_C1D9_2B7A_4F60_E38D_95C2_17AB,
        192'h0B7D_29E4_C15A_8F36_D0E2_7A91_4C5B_E3F8_2196_A0D5,
        192'h3A5F_0C91_7E24_B6D8_1F03_C5A7_9B2E_6D41
    };
endpackage

// File: rtl/bch_next_state.sv
// Combinational byte step of the remainder: rem_o = F^W * (rem + M).
// The W bits of M sit in the top W positions, and the MSB is the earliest bit.
// Only the W columns of F^W that carry feedback are stored, one set for each
// polynomial. The remaining columns are a plain shift by W.
// Assumes W <= smallest degree.
module bch_next_state #(
    parameter int W     = 8,
    parameter int NMAX  = 192,
    parameter int NPOLY = 4,
    parameter int SELW  = 2,
    parameter logic [NPOLY-1:0][NMAX-1:0] TAPS = bch_par_pkg::BCH_TAPS,
    parameter logic [NPOLY-1:0][15:0]     DEGS = bch_par_pkg::BCH_DEGS
) (
    input  logic [NMAX-1:0] rem_i,
    input  logic            clear_i,
    input  logic [W-1:0]    data_i,
    input  logic [SELW-1:0] sel_i,
    output logic [NMAX-1:0] rem_o
);
    typedef logic [NPOLY-1:0][W-1:0][NMAX-1:0] col_tab_t;

    // Step the padded serial divider W times from a single set bit near the top
    function automatic col_tab_t build_cols();
        col_tab_t          t;
        logic [NMAX-1:0]   g;
        logic [NMAX-1:0]   s;
        logic              fb;
        t = '0;
        for (int p = 0; p < NPOLY; p++) begin
            g = TAPS[p] << (NMAX - int'(DEGS[p]));
            for (int j = 0; j < W; j++) begin
                s = '0;
                s[NMAX-1-j] = 1'b1;
                for (int k = 0; k < W; k++) begin
                    fb = s[NMAX-1];
                    s  = s << 1;
                    if (fb) s = s ^ g;
                end
                t[p][j] = s;
            end
        end
        return t;
    endfunction

    localparam col_tab_t COLS = build_cols();

    logic [NMAX-1:0]         v;
    logic [W-1:0][NMAX-1:0]  col_sel;
    logic [W-1:0][NMAX-1:0]  term;

    assign v       = (clear_i ? '0 : rem_i) ^ {data_i, {(NMAX-W){1'b0}}};
    assign col_sel = COLS[sel_i];

    for (genvar j = 0; j < W; j++) begin : g_term
        assign term[j] = v[NMAX-1-j] ? col_sel[j] : '0;
    end

    // XOR the shifted vector with the selected feedback columns
    always_comb begin
        rem_o = v << W;
        for (int j = 0; j < W; j++) rem_o = rem_o ^ term[j];
    end
endmodule

// File: rtl/bch_par_seq.sv
// Parity-phase sequencer: loads the parity byte count on the last message
// byte and counts down one per clock. It is active while the count is nonzero.
// Assumes start_i is never raised while active_o is high.
module bch_par_seq #(
    parameter int CNTW = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            start_i,
    input  logic [CNTW-1:0] len_i,
    output logic            active_o,
    output logic            final_o
);
    logic [CNTW-1:0] cnt_q;

    // Parity byte countdown
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (start_i)         cnt_q <= len_i;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign active_o = (cnt_q != '0);
    assign final_o  = (cnt_q == CNTW'(1));
endmodule

// File: rtl/bch_par_enc.sv
// Byte-parallel systematic BCH encoder with a generator chosen per frame.
// Message bytes are copied to the output and folded into the remainder in
// the same clock. After in_last, the top deg bits of the remainder leave as
// parity bytes, MSB first.
// Assumes message length is whole bytes, and in_sel is valid on in_sof.
module bch_par_enc #(
    parameter int W     = bch_par_pkg::BCH_W,
    parameter int NMAX  = bch_par_pkg::BCH_NMAX,
    parameter int NPOLY = bch_par_pkg::BCH_NPOLY,
    parameter int SELW  = (NPOLY > 1) ? $clog2(NPOLY) : 1,
    parameter logic [NPOLY-1:0][NMAX-1:0] TAPS = bch_par_pkg::BCH_TAPS,
    parameter logic [NPOLY-1:0][15:0]     DEGS = bch_par_pkg::BCH_DEGS
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_sof,
    input  logic            in_valid,
    input  logic [W-1:0]    in_data,
    input  logic            in_last,
    input  logic [SELW-1:0] in_sel,
    output logic            in_ready,
    output logic            out_valid,
    output logic [W-1:0]    out_data,
    output logic            out_last
);
    localparam int CNTW = $clog2(NMAX / W + 1);
    localparam int WSH  = $clog2(W);

    logic [NMAX-1:0] rem_q;
    logic [NMAX-1:0] rem_nxt;
    logic [SELW-1:0] sel_q;
    logic [SELW-1:0] sel_use;
    logic [CNTW-1:0] par_len;
    logic            accept;
    logic            par_active;
    logic            par_final;

    assign accept   = in_valid && in_ready;
    assign sel_use  = in_sof ? in_sel : sel_q;
    assign par_len  = CNTW'(DEGS[sel_use] >> WSH);
    assign in_ready = !par_active;

    bch_next_state #(
        .W(W), .NMAX(NMAX), .NPOLY(NPOLY), .SELW(SELW),
        .TAPS(TAPS), .DEGS(DEGS)
    ) u_next (
        .rem_i   (rem_q),
        .clear_i (in_sof),
        .data_i  (in_data),
        .sel_i   (sel_use),
        .rem_o   (rem_nxt)
    );

    bch_par_seq #(.CNTW(CNTW)) u_seq (
        .clk      (clk),
        .rst_n    (rst_n),
        .start_i  (accept && in_last),
        .len_i    (par_len),
        .active_o (par_active),
        .final_o  (par_final)
    );

    // Remainder, latched select and the registered codeword stream
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q     <= '0;
            sel_q     <= '0;
            out_valid <= 1'b0;
            out_data  <= '0;
            out_last  <= 1'b0;
        end else if (accept) begin
            rem_q     <= rem_nxt;
            if (in_sof) sel_q <= in_sel;
            out_valid <= 1'b1;
            out_data  <= in_data;
            out_last  <= 1'b0;
        end else if (par_active) begin
            rem_q     <= rem_q << W;
            out_valid <= 1'b1;
            out_data  <= rem_q[NMAX-1 -: W];
            out_last  <= par_final;
        end else begin
            out_valid <= 1'b0;
            out_last  <= 1'b0;
        end
    end
endmodule

// File: rtl/bch_par_enc_chk.sv
// Port-level protocol checks for bch_par_enc, attached by bind.
module bch_par_enc_chk #(
    parameter int W = 8
) (
    input logic         clk,
    input logic         rst_n,
    input logic         in_valid,
    input logic [W-1:0] in_data,
    input logic         in_last,
    input logic         in_ready,
    input logic         out_valid,
    input logic [W-1:0] out_data,
    input logic         out_last
);
    // R2: an accepted byte is echoed one clock later
    assert_echo_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && in_ready) |=>
            (out_valid && !out_last && out_data == $past(in_data)));

    // R3: while input is held off, a parity byte is produced every clock
    assert_par_stream_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !in_ready) |=> out_valid);

    // R4: the frame marker only accompanies a valid byte
    assert_last_valid_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    // R4: input reopens with the final parity byte
    assert_last_ready_R4: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> in_ready);

    // R5: the last message byte closes the input
    assert_ready_drop_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && in_valid && in_ready && in_last) |=> !in_ready);
endmodule

bind bch_par_enc bch_par_enc_chk #(.W(W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_last   (in_last),
    .in_ready  (in_ready),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_last  (out_last)
);

// File: tb/tb_bch_par_enc.sv
// Directed bench: each scenario drives frames and checks the codeword stream
// against a bit-serial divider of the unpadded degree.
module tb_bch_par_enc;
    import bch_par_pkg::*;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       in_sof = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = 8'h00;
    logic       in_last = 1'b0;
    logic [1:0] in_sel = 2'd0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;

    always #2 clk = ~clk;

    bch_par_enc dut (
        .clk(clk), .rst_n(rst_n), .in_sof(in_sof), .in_valid(in_valid),
        .in_data(in_data), .in_last(in_last), .in_sel(in_sel),
        .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
        .out_last(out_last)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    logic [7:0] msg [256];
    logic [7:0] exp_data [1024];
    bit         exp_last [1024];
    bit         exp_par  [1024];
    int         exp_n = 0;
    logic [7:0] got_data [1024];
    bit         got_last [1024];
    int         got_n = 0;

    // Capture every output byte away from the active edge
    always @(negedge clk) begin
        if (rst_n && out_valid && got_n < 1024) begin
            got_data[got_n] = out_data;
            got_last[got_n] = out_last;
            got_n++;
        end
    end

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] expv);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, expv);
        end
    endtask

    task automatic fill_msg(input int seed, input int k, input bit zero);
        for (int i = 0; i < k; i++)
            msg[i] = zero ? 8'h00 : 8'((seed * 131 + i * 29 + i * i * 7) ^ (seed >> 1));
    endtask

    // Serial division reference for one frame, appended to the expected stream
    task automatic add_expected(input int sel, input int k);
        logic [191:0] r, taps, mask;
        int d;
        logic fb;
        d    = int'(BCH_DEGS[sel]);
        taps = BCH_TAPS[sel];
        mask = (192'(1) << d) - 192'(1);
        r    = '0;
        for (int i = 0; i < k; i++) begin
            exp_data[exp_n] = msg[i]; exp_last[exp_n] = 1'b0; exp_par[exp_n] = 1'b0;
            exp_n++;
            for (int b = 7; b >= 0; b--) begin
                fb = r[d-1] ^ msg[i][b];
                r  = r << 1;
                if (fb) r = r ^ taps;
                r = r & mask;
            end
        end
        for (int i = 0; i < d / 8; i++) begin
            exp_data[exp_n] = r[d-1-8*i -: 8];
            exp_last[exp_n] = (i == d / 8 - 1);
            exp_par[exp_n]  = 1'b1;
            exp_n++;
        end
    endtask

    task automatic drive_frame(input int sel, input int k, input bit gaps,
                               input bit glitch, input bit junk);
        int held;
        for (int i = 0; i < k; i++) begin
            @(negedge clk);
            while (!in_ready) @(negedge clk);
            if (gaps && (i % 3 == 1)) begin
                in_valid = 1'b0;
                @(negedge clk);
            end
            in_valid = 1'b1;
            in_data  = msg[i];
            in_sof   = (i == 0);
            in_last  = (i == k - 1);
            in_sel   = (i == 0 || !glitch) ? 2'(sel) : ~2'(sel);
        end
        @(negedge clk);
        held = 0;
        while (!in_ready) begin
            held++;
            in_valid = junk;
            in_data  = 8'hA5; in_sof = 1'b0; in_last = 1'b1;
            @(negedge clk);
        end
        in_valid = 1'b0; in_sof = 1'b0; in_last = 1'b0;
        if (junk)
            chk(held == int'(BCH_DEGS[sel]) / 8, "R5", "ready-low cycles",
                64'(held), 64'(int'(BCH_DEGS[sel]) / 8));
    endtask

    task automatic finish_frames(input string rq);
        int t;
        t = 0;
        while (got_n < exp_n && t < 3000) begin @(negedge clk); t++; end
        repeat (10) @(negedge clk);
        chk(got_n == exp_n, rq, "byte count", 64'(got_n), 64'(exp_n));
        for (int i = 0; i < exp_n && i < got_n; i++) begin
            chk(got_data[i] == exp_data[i], rq,
                exp_par[i] ? $sformatf("R3 parity byte %0d", i) : $sformatf("R2 message byte %0d", i),
                64'(got_data[i]), 64'(exp_data[i]));
            chk(got_last[i] == exp_last[i], rq, $sformatf("R4 last flag %0d", i),
                64'(got_last[i]), 64'(exp_last[i]));
        end
        got_n = 0;
        exp_n = 0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid in reset", 64'(out_valid), 64'(0));
        rst_n = 1'b1;
        @(negedge clk);
        chk(out_valid == 1'b0, "R1", "out_valid after reset", 64'(out_valid), 64'(0));
        chk(out_last == 1'b0, "R1", "out_last after reset", 64'(out_last), 64'(0));
        chk(in_ready == 1'b1, "R1", "in_ready after reset", 64'(in_ready), 64'(1));
    endtask

    task automatic t_each_poly();
        for (int s = 0; s < 4; s++) begin
            fill_msg(11 + s, 24, 1'b0);
            add_expected(s, 24);
            drive_frame(s, 24, 1'b0, 1'b0, 1'b0);
            finish_frames($sformatf("R6 select %0d", s));
        end
    endtask

    task automatic t_single_byte();
        fill_msg(5, 1, 1'b0);
        add_expected(2, 1);
        drive_frame(2, 1, 1'b0, 1'b0, 1'b0);
        finish_frames("R9");
    endtask

    task automatic t_zero_msg();
        fill_msg(0, 16, 1'b1);
        add_expected(3, 16);
        drive_frame(3, 16, 1'b0, 1'b0, 1'b0);
        finish_frames("R10");
    endtask

    task automatic t_gaps();
        fill_msg(77, 17, 1'b0);
        add_expected(1, 17);
        drive_frame(1, 17, 1'b1, 1'b0, 1'b0);
        finish_frames("R8");
    endtask

    task automatic t_sel_change();
        fill_msg(91, 12, 1'b0);
        add_expected(0, 12);
        drive_frame(0, 12, 1'b0, 1'b1, 1'b0);
        finish_frames("R6 held select");
    endtask

    task automatic t_ready_hold();
        fill_msg(33, 9, 1'b0);
        add_expected(2, 9);
        drive_frame(2, 9, 1'b0, 1'b0, 1'b1);
        finish_frames("R5");
    endtask

    task automatic t_b2b();
        fill_msg(201, 5, 1'b0);
        add_expected(0, 5);
        drive_frame(0, 5, 1'b0, 1'b0, 1'b0);
        fill_msg(202, 9, 1'b0);
        add_expected(3, 9);
        drive_frame(3, 9, 1'b0, 1'b0, 1'b0);
        fill_msg(203, 2, 1'b0);
        add_expected(1, 2);
        drive_frame(1, 2, 1'b0, 1'b0, 1'b0);
        finish_frames("R7");
    endtask

    // Watchdog: a hung run is a failed check
    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        t_reset();
        t_each_poly();
        t_single_byte();
        t_zero_msg();
        t_gaps();
        t_sel_change();
        t_ready_hold();
        t_b2b();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
        $finish;
    end
endmodule